// File: doc/BRIEF.md
# Programmable-Priority Interrupt Allocator

The block collects eight interrupt sources and routes them onto three request lines of fixed priority. Three sources are external pins with a per-pin choice of rising or falling edge; the other five are event strobes from on-chip peripherals: conversion done, serial port, and three timers. Every source owns a sticky pending latch. A register-mapped allocation word holds one 4-bit field per request line, and each field names the source that drives that line. Software can read all pending bits at once and clear any subset of them. That clear uses the same register as a 4-bit bank-select field, and the clear leaves that field unchanged.

A global enable gates every request line. Of the lines that are asserted, only the highest-priority one is presented to the core, together with a 2-bit level code. Line 0 has the highest priority. The register interface is a single-cycle write strobe with a combinational read port.

Top module: `irq_alloc`

## Requirements
- R1: After reset the control register reads 0x0000 (interrupts disabled, all three pins in falling-edge mode). The allocation register reads 0x0FFF, so no line has a source. The status register reads 0x0000. irq_valid_o is 0.
- R2: External pin k has a polarity bit in control bit k+1. With that bit at 1, a 0-to-1 transition on pin k sets pending bit 5+k on the next clock edge. With that bit at 0, a 1-to-0 transition sets it instead. The opposite transition sets nothing.
- R3: While periph_evt_i[j] is high at a clock edge, pending bit j is set by that edge. The bit order is 0 conversion done, 1 serial, 2 timer 0, 3 timer 1, 4 timer 2.
- R4: A pending bit stays set until it is cleared. A clear is a write to address 2 with data bit 15 at 1. That write clears pending bit i when data bit 4+i is 1, and it leaves the other pending bits and the bank field unchanged.
- R5: A write to address 2 with data bit 15 at 0 loads data bits 3..0 into the bank field and leaves every pending bit unchanged.
- R6: When a source event and a clear of the same pending bit fall on the same clock edge, the bit ends up set.
- R7: The allocation register sits at address 1. Field bits 4l+3..4l select the source for line l (l = 0, 1, 2), written as the pending-bit index 0..7. A field value of 8..15 means the line has no source. Line l is asserted exactly when the enable is 1, the field is below 8 and the selected pending bit is 1.
- R8: With the global enable (control bit 0) at 0, all request lines and irq_valid_o are 0, and the pending latches still capture events.
- R9: irq_valid_o is 1 when any request line is asserted. irq_level_o then gives the lowest-numbered asserted line, where line 0 has the highest priority. When irq_valid_o is 0, irq_level_o is 0.
- R10: Reads are combinational. Address 0 returns {12'b0, polarity[2:0], enable}. Address 1 returns {4'b0, allocation}. Address 2 returns {4'b0, pending[7:0], bank[3:0]}. Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 3 | External interrupt pins (synchronous to clk_i) |
| periph_evt_i | input | 5 | Peripheral event strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_req_o | output | 3 | Raw request lines, index 0 highest priority |
| irq_valid_o | output | 1 | A request is presented |
| irq_level_o | output | 2 | Level of the presented request |

## Verification
Two functions can act on the same pending latch in one cycle: a source event setting it and a software clear resetting it. A directed step first clears the conversion-done bit. It then drives that source's strobe in the same cycle as a clear write to it, and the following read of the status register must show the bit set, with the bank field intact. Random traffic adds further coincidences of edges, strobes, clears and allocation rewrites. After every cycle a bench model recomputes the request lines, the priority level and the read data, and the design must match it.

// File: rtl/irq_alloc_pkg.sv
package irq_alloc_pkg;
  localparam int NUM_EXT  = 3;
  localparam int NUM_PER  = 5;
  localparam int NUM_SRC  = NUM_EXT + NUM_PER;
  localparam int NUM_LVL  = 3;
  localparam int SEL_W    = 4;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int BANK_W   = 4;
  localparam int PEND_LSB = BANK_W;
  localparam int CLR_BIT  = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_ALLOC = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign evt_o[i] = rise_i[i] ? (sig_i[i] & ~prev_q[i]) : (~sig_i[i] & prev_q[i]);
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set has priority so an event coinciding with a clear is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NUM_SRC = 8,
  parameter int NUM_LVL = 3,
  parameter int SEL_W   = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_LVL*SEL_W-1:0] alloc_i,
  input  logic                     en_i,
  output logic [NUM_LVL-1:0]       req_o,
  output logic                     valid_o,
  output logic [LVL_W-1:0]         level_o
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [SEL_W-1:0] sel;
    logic             hit;
    assign sel      = alloc_i[l*SEL_W +: SEL_W];
    assign hit      = (int'(sel) < NUM_SRC) && pend_i[sel[SRC_W-1:0]];
    assign req_o[l] = en_i && hit;
  end

  always_comb begin
    level_o = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (req_o[l]) level_o = LVL_W'(l);
    end
  end

  assign valid_o = |req_o;
endmodule

// File: rtl/irq_alloc.sv
module irq_alloc
  import irq_alloc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_PER-1:0] periph_evt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_LVL-1:0] irq_req_o,
  output logic               irq_valid_o,
  output logic [LVL_W-1:0]   irq_level_o
);
  localparam int ALLOC_W = NUM_LVL * SEL_W;

  logic                en_q;
  logic [NUM_EXT-1:0]  pol_q;
  logic [ALLOC_W-1:0]  alloc_q;
  logic [BANK_W-1:0]   bank_q;
  logic [NUM_EXT-1:0]  ext_evt;
  logic [NUM_SRC-1:0]  set_vec, clr_vec, pend;
  logic                wr_ctrl, wr_alloc, wr_stat, clr_op;
  logic                unused_wdata;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_alloc = reg_we_i && (reg_addr_i == ADDR_ALLOC);
  assign wr_stat  = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign clr_op   = wr_stat && reg_wdata_i[CLR_BIT];
  assign unused_wdata = ^reg_wdata_i[CLR_BIT-1:PEND_LSB+NUM_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pol_q   <= '0;
      alloc_q <= '1;
      bank_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata_i[0];
        pol_q <= reg_wdata_i[NUM_EXT:1];
      end
      if (wr_alloc) alloc_q <= reg_wdata_i[ALLOC_W-1:0];
      if (wr_stat && !reg_wdata_i[CLR_BIT]) bank_q <= reg_wdata_i[BANK_W-1:0];
    end
  end

  irq_edge_det #(.N(NUM_EXT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (ext_irq_i),
    .rise_i (pol_q),
    .evt_o  (ext_evt)
  );

  assign set_vec = {ext_evt, periph_evt_i};
  assign clr_vec = clr_op ? reg_wdata_i[PEND_LSB +: NUM_SRC] : '0;

  irq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  irq_prio_sel #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SEL_W(SEL_W)) u_prio (
    .pend_i  (pend),
    .alloc_i (alloc_q),
    .en_i    (en_q),
    .req_o   (irq_req_o),
    .valid_o (irq_valid_o),
    .level_o (irq_level_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o[NUM_EXT:0] = {pol_q, en_q};
      ADDR_ALLOC: reg_rdata_o[ALLOC_W-1:0] = alloc_q;
      ADDR_STAT:  reg_rdata_o[PEND_LSB+NUM_SRC-1:0] = {pend, bank_q};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_alloc_chk.sv
module irq_alloc_chk
  import irq_alloc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_PER-1:0] periph_evt_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [NUM_LVL-1:0] irq_req_o,
  input logic               irq_valid_o,
  input logic [LVL_W-1:0]   irq_level_o,
  input logic               en_q,
  input logic [NUM_SRC-1:0] pend,
  input logic [BANK_W-1:0]  bank_q
);
  logic clr_wr, bank_wr;
  assign clr_wr  = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[CLR_BIT];
  assign bank_wr = reg_we_i && (reg_addr_i == ADDR_STAT) && !reg_wdata_i[CLR_BIT];

  a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend[NUM_PER-1:0] & $past(periph_evt_i)) == $past(periph_evt_i)));

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

  a_r5_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_wr |=> (bank_q == $past(reg_wdata_i[BANK_W-1:0])));

  a_r4_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> $stable(bank_q));

  a_r8_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (irq_req_o == '0) && !irq_valid_o);

  a_r9_valid_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o == (irq_req_o != '0));

  a_r9_level_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> irq_req_o[irq_level_o] &&
                    ((irq_req_o & ((NUM_LVL'(1) << irq_level_o) - NUM_LVL'(1))) == '0));

  a_r9_level_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> irq_level_o == '0);
endmodule

bind irq_alloc irq_alloc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .periph_evt_i (periph_evt_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .irq_req_o    (irq_req_o),
  .irq_valid_o  (irq_valid_o),
  .irq_level_o  (irq_level_o),
  .en_q         (en_q),
  .pend         (pend),
  .bank_q       (bank_q)
);

// File: tb/irq_alloc_tb.sv
module irq_alloc_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  ext = 0;
  logic [4:0]  per = 0;
  logic        we = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [2:0]  req;
  logic        valid;
  logic [1:0]  level;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic        m_en;
  logic [2:0]  m_pol, m_prev;
  logic [11:0] m_alloc;
  logic [3:0]  m_bank;
  logic [7:0]  m_pend;

  always #4 clk = ~clk;

  irq_alloc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .periph_evt_i(per),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o(req), .irq_valid_o(valid), .irq_level_o(level)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_req();
    logic [2:0] r;
    for (int l = 0; l < 3; l++) begin
      logic [3:0] s;
      s = m_alloc[4*l +: 4];
      r[l] = m_en && (s < 8) && m_pend[s[2:0]];
    end
    return r;
  endfunction

  function automatic logic [1:0] exp_level(logic [2:0] r);
    if (r[0]) return 2'd0;
    if (r[1]) return 2'd1;
    if (r[2]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {12'b0, m_pol, m_en};
      2'd1: return {4'b0, m_alloc};
      2'd2: return {4'b0, m_pend, m_bank};
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_en = 0; m_pol = 0; m_prev = 0; m_alloc = 12'hFFF; m_bank = 0; m_pend = 0;
  endtask

  // called at a negedge: drive, advance model, wait one edge, compare
  task automatic cyc(logic [2:0] e, logic [4:0] p, logic w, logic [1:0] a, logic [15:0] d);
    logic [7:0] set, clr;
    logic [2:0] ee;
    logic [2:0] r;
    ext = e; per = p; we = w; addr = a; wdata = d;
    for (int i = 0; i < 3; i++)
      ee[i] = m_pol[i] ? (e[i] & ~m_prev[i]) : (~e[i] & m_prev[i]);
    set = {ee, p};
    clr = 0;
    if (w) begin
      case (a)
        2'd0: begin m_en = d[0]; m_pol = d[3:1]; end
        2'd1: m_alloc = d[11:0];
        2'd2: if (d[15]) clr = d[11:4]; else m_bank = d[3:0];
        default: ;
      endcase
    end
    m_pend = (m_pend & ~clr) | set;
    m_prev = e;
    @(posedge clk); @(negedge clk);
    r = exp_req();
    chk("R7 request lines", 32'(req), 32'(r));
    chk("R9 valid", 32'(valid), 32'(|r));
    chk("R9 level", 32'(level), 32'(exp_level(r)));
    chk("R10 read data", 32'(rdata), 32'(exp_rd(a)));
  endtask

  task automatic rd_stat(string tag, logic [15:0] exp);
    cyc(ext, 5'b0, 1'b0, 2'd2, 16'h0);
    chk(tag, 32'(rdata), 32'(exp));
  endtask

  initial begin
    model_reset();
    #20; @(negedge clk);
    rst_n = 1;
    addr = 2'd0; #1; chk("R1 ctrl reset", 32'(rdata), 32'h0000);
    addr = 2'd1; #1; chk("R1 alloc reset", 32'(rdata), 32'h0FFF);
    addr = 2'd2; #1; chk("R1 status reset", 32'(rdata), 32'h0000);
    chk("R1 valid reset", 32'(valid), 32'h0);
    @(negedge clk);

    cyc(3'b000, 5'b0, 1, 2'd0, 16'h000F);
    cyc(3'b000, 5'b0, 1, 2'd1, 16'h0F02);
    cyc(3'b000, 5'b00001, 0, 2'd2, 16'h0);
    chk("R3 adc pending", 32'(rdata), 32'h0010);
    chk("R9 level ISR1", 32'({valid, level}), 32'b101);
    cyc(3'b000, 5'b00100, 0, 2'd2, 16'h0);
    chk("R3 timer0 pending", 32'(rdata), 32'h0050);
    chk("R9 level ISR0", 32'({req, valid, level}), 32'b011_1_00);
    cyc(3'b001, 5'b0, 0, 2'd2, 16'h0);
    chk("R2 rising sets", 32'(rdata), 32'h0250);
    cyc(3'b000, 5'b0, 0, 2'd2, 16'h0);
    chk("R2 falling ignored in rising mode", 32'(rdata), 32'h0250);
    cyc(3'b000, 5'b0, 1, 2'd2, 16'h8040);
    chk("R4 selective clear", 32'(rdata), 32'h0210);
    chk("R4 request drops", 32'({req, level}), 32'b010_01);
    cyc(3'b000, 5'b0, 1, 2'd2, 16'h0005);
    chk("R5 bank write keeps pending", 32'(rdata), 32'h0215);
    cyc(3'b000, 5'b0, 1, 2'd2, 16'h8010);
    chk("R4 clear adc", 32'(rdata), 32'h0205);
    cyc(3'b000, 5'b00001, 1, 2'd2, 16'h8010);
    chk("R6 set wins over clear", 32'(rdata), 32'h0215);
    cyc(3'b000, 5'b0, 1, 2'd0, 16'h000E);
    chk("R8 disabled no request", 32'({req, valid}), 32'b000_0);
    cyc(3'b000, 5'b00010, 0, 2'd2, 16'h0);
    chk("R8 pending still latches", 32'(rdata), 32'h0235);
    chk("R8 still no valid", 32'(valid), 32'h0);
    cyc(3'b000, 5'b0, 1, 2'd0, 16'h000F);
    cyc(3'b000, 5'b0, 1, 2'd1, 16'h01F5);
    chk("R7 none field and remap", 32'({req, valid, level}), 32'b101_1_00);
    cyc(3'b000, 5'b0, 1, 2'd2, 16'h8FF0);
    chk("R4 clear all keeps bank", 32'(rdata), 32'h0005);
    chk("R4 no request after clear", 32'(valid), 32'h0);
    cyc(3'b000, 5'b0, 1, 2'd0, 16'h000D);
    cyc(3'b001, 5'b0, 0, 2'd2, 16'h0);
    chk("R2 rising ignored in falling mode", 32'(rdata), 32'h0005);
    cyc(3'b000, 5'b0, 0, 2'd2, 16'h0);
    chk("R2 falling sets", 32'(rdata), 32'h0205);

    void'($urandom(32'h1234));
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] p;
      logic [15:0] d;
      p = 0;
      for (int j = 0; j < 5; j++) p[j] = ($urandom_range(7) == 0);
      d = 16'($urandom);
      cyc(3'($urandom), p, ($urandom_range(3) == 0), 2'($urandom), d);
    end
    rd_stat("R10 final status", exp_rd(2'd2));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule